// File: doc/BRIEF.md
# Banked General-Purpose Register File with Shadow Sets

This block is the integer register file of a three-operand processor core. It holds 32 registers of 32 bits, indexed by a 5-bit number. It serves two combinational source reads and one clocked destination write per cycle. The storage is replicated into a parameterised number of banks, from one to eight. An interrupt entry can move execution onto a fresh bank, so no registers are spilled to memory, and an interrupt exit moves it back.

Register 0 reads as zero in every bank. A write issued in the same cycle as a read of the same register is forwarded straight to the read port. A separate pair of 32-bit result registers sits outside the banks and takes the upper and lower halves of a 64-bit multiply or divide result.

The bank in use is held in a current-set field. A switch command loads a new bank number into that field and saves the number it held before in a previous-set field. A return command loads the current set from the previous set. The interrupt controller, the multiply/divide datapath and the pipeline all sit outside this block and drive these commands.

Top module: `shadow_regfile`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cur_set`, `prev_set`, `hi_data` and `lo_data` are all zero.
- R2: A value written with `dst_we` to a nonzero index is returned on both source ports from the next cycle on, for as long as the same bank is current and that register is not written again.
- R3: A source index of 0 always reads 0, and a write to index 0 changes no register.
- R4: When `dst_we` is high and `dst_idx` is nonzero and equal to a source index, that source port returns `dst_wdata` in the same cycle.
- R5: A write changes only the register in the current bank; the same index in every other bank keeps its value.
- R6: When `bank_switch` is high and `bank_target` is below NUM_BANKS, then after the next clock `cur_set` equals `bank_target` and `prev_set` equals the old `cur_set`.
- R7: When `bank_return` is high and `bank_switch` is low, then after the next clock `cur_set` equals the old `prev_set` and `prev_set` is unchanged.
- R8: When `bank_switch` and `bank_return` are high together, the switch takes effect and the return is ignored.
- R9: A switch to a `bank_target` of NUM_BANKS or above loads bank 0 into `cur_set`, and the old `cur_set` still moves into `prev_set`.
- R10: When `hilo_we` is high, `hi_data` takes bits 63:32 and `lo_data` takes bits 31:0 of `hilo_wdata` after the next clock. Otherwise both hold their values.
- R11: Reads and the write in a cycle that also carries a switch or a return use the bank that was current during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bank_switch | input | 1 | Make `bank_target` current and save the old current bank |
| bank_target | input | 3 | Bank requested by a switch |
| bank_return | input | 1 | Make the saved previous bank current again |
| cur_set | output | 3 | Bank serving reads and writes |
| prev_set | output | 3 | Bank saved by the last switch |
| src_a_idx | input | 5 | First source register index |
| src_a_data | output | 32 | First source register value |
| src_b_idx | input | 5 | Second source register index |
| src_b_data | output | 32 | Second source register value |
| dst_we | input | 1 | Destination write enable |
| dst_idx | input | 5 | Destination register index |
| dst_wdata | input | 32 | Destination write data |
| hilo_we | input | 1 | Load both result halves |
| hilo_wdata | input | 64 | Upper half goes to HI, lower half to LO |
| hi_data | output | 32 | Upper result register |
| lo_data | output | 32 | Lower result register |

## Verification
The bench builds the block with NUM_BANKS set to 5. The three-bit target field can then name banks 5, 6 and 7, which do not exist, so the clamp to bank 0 is exercised by both random and directed switches. Five live banks also leave room for switch and return chains that visit several banks, which shows that a write into one bank leaves the other four intact.

// File: rtl/srf_pkg.sv
package srf_pkg;

    localparam int unsigned SRF_XLEN      = 32;
    localparam int unsigned SRF_NREGS     = 32;
    localparam int unsigned SRF_IDX_W     = $clog2(SRF_NREGS);
    localparam int unsigned SRF_MAX_BANKS = 8;
    localparam int unsigned SRF_SET_W     = $clog2(SRF_MAX_BANKS);
    localparam int unsigned SRF_NUM_RD    = 2;

    typedef logic [SRF_XLEN-1:0]  word_t;
    typedef logic [SRF_IDX_W-1:0] ridx_t;
    typedef logic [SRF_SET_W-1:0] set_t;

    typedef struct packed {
        logic  en;
        ridx_t idx;
        word_t data;
    } gpr_wr_t;

    typedef struct packed {
        word_t hi;
        word_t lo;
    } hilo_t;

    typedef enum logic [1:0] {
        SET_HOLD   = 2'd0,
        SET_SWITCH = 2'd1,
        SET_RETURN = 2'd2
    } set_cmd_e;

    function automatic set_t srf_clamp(input set_t req, input int unsigned nbanks);
        return (32'(req) < nbanks) ? req : '0;
    endfunction

    function automatic set_cmd_e srf_decode(input logic sw, input logic ret);
        if (sw)       return SET_SWITCH;
        else if (ret) return SET_RETURN;
        else          return SET_HOLD;
    endfunction

endpackage

// File: rtl/srf_set_ctrl.sv
module srf_set_ctrl
    import srf_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_req,
    input  set_t sw_target,
    input  logic ret_req,
    output set_t cur_q,
    output set_t prev_q
);

    set_cmd_e cmd;
    set_t     target_ok;

    always_comb begin
        cmd       = srf_decode(sw_req, ret_req);
        target_ok = srf_clamp(sw_target, NUM_BANKS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            case (cmd)
                SET_SWITCH: begin
                    prev_q <= cur_q;
                    cur_q  <= target_ok;
                end
                SET_RETURN: cur_q <= prev_q;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/srf_bank_array.sv
module srf_bank_array
    import srf_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned NUM_RD    = SRF_NUM_RD
) (
    input  logic                              clk,
    input  set_t                              bank,
    input  gpr_wr_t                           wr,
    input  logic [NUM_RD-1:0][SRF_IDX_W-1:0]  rd_idx,
    output logic [NUM_RD-1:0][SRF_XLEN-1:0]   rd_data
);

    localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    word_t             mem [NUM_BANKS][SRF_NREGS];
    logic [BANK_W-1:0] bsel;
    logic              wr_live;

    always_comb begin
        bsel    = BANK_W'(bank);
        wr_live = wr.en && (wr.idx != '0);
    end

    always_ff @(posedge clk) begin
        if (wr_live) begin
            mem[bsel][wr.idx] <= wr.data;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        ridx_t idx_p;
        word_t stored_p;
        always_comb begin
            idx_p    = rd_idx[p];
            stored_p = mem[bsel][idx_p];
            if (idx_p == '0) begin
                rd_data[p] = '0;
            end else if (wr_live && (wr.idx == idx_p)) begin
                rd_data[p] = wr.data;
            end else begin
                rd_data[p] = stored_p;
            end
        end
    end

endmodule

// File: rtl/srf_hilo.sv
module srf_hilo
    import srf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  hilo_t wdata,
    output hilo_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
    import srf_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bank_switch,
    input  logic [2:0]  bank_target,
    input  logic        bank_return,
    output logic [2:0]  cur_set,
    output logic [2:0]  prev_set,
    input  logic [4:0]  src_a_idx,
    output logic [31:0] src_a_data,
    input  logic [4:0]  src_b_idx,
    output logic [31:0] src_b_data,
    input  logic        dst_we,
    input  logic [4:0]  dst_idx,
    input  logic [31:0] dst_wdata,
    input  logic        hilo_we,
    input  logic [63:0] hilo_wdata,
    output logic [31:0] hi_data,
    output logic [31:0] lo_data
);

    set_t                                    cur_q;
    set_t                                    prev_q;
    gpr_wr_t                                 wr_pkt;
    logic [SRF_NUM_RD-1:0][SRF_IDX_W-1:0]    rd_idx;
    logic [SRF_NUM_RD-1:0][SRF_XLEN-1:0]     rd_data;
    hilo_t                                   hilo_q;

    always_comb begin
        wr_pkt.en   = dst_we;
        wr_pkt.idx  = dst_idx;
        wr_pkt.data = dst_wdata;
        rd_idx[0]   = src_a_idx;
        rd_idx[1]   = src_b_idx;
    end

    srf_set_ctrl #(
        .NUM_BANKS (NUM_BANKS)
    ) u_set_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sw_req    (bank_switch),
        .sw_target (bank_target),
        .ret_req   (bank_return),
        .cur_q     (cur_q),
        .prev_q    (prev_q)
    );

    srf_bank_array #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_RD    (SRF_NUM_RD)
    ) u_banks (
        .clk     (clk),
        .bank    (cur_q),
        .wr      (wr_pkt),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    srf_hilo u_hilo (
        .clk   (clk),
        .rst   (rst),
        .we    (hilo_we),
        .wdata (hilo_wdata),
        .q     (hilo_q)
    );

    always_comb begin
        cur_set    = cur_q;
        prev_set   = prev_q;
        src_a_data = rd_data[0];
        src_b_data = rd_data[1];
        hi_data    = hilo_q.hi;
        lo_data    = hilo_q.lo;
    end

endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
    parameter int unsigned NUM_BANKS = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        bank_switch,
    input logic [2:0]  bank_target,
    input logic        bank_return,
    input logic [2:0]  cur_set,
    input logic [2:0]  prev_set,
    input logic [4:0]  src_a_idx,
    input logic [31:0] src_a_data,
    input logic [4:0]  src_b_idx,
    input logic [31:0] src_b_data,
    input logic        dst_we,
    input logic [4:0]  dst_idx,
    input logic [31:0] dst_wdata,
    input logic        hilo_we,
    input logic [63:0] hilo_wdata,
    input logic [31:0] hi_data,
    input logic [31:0] lo_data
);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_set == 3'd0 && prev_set == 3'd0 && hi_data == 32'd0 && lo_data == 32'd0));

    a_r3_zero_a: assert property (@(posedge clk) disable iff (rst)
        (src_a_idx == 5'd0) |-> (src_a_data == 32'd0));

    a_r3_zero_b: assert property (@(posedge clk) disable iff (rst)
        (src_b_idx == 5'd0) |-> (src_b_data == 32'd0));

    a_r4_forward_a: assert property (@(posedge clk) disable iff (rst)
        (dst_we && dst_idx != 5'd0 && src_a_idx == dst_idx) |-> (src_a_data == dst_wdata));

    a_r4_forward_b: assert property (@(posedge clk) disable iff (rst)
        (dst_we && dst_idx != 5'd0 && src_b_idx == dst_idx) |-> (src_b_data == dst_wdata));

    a_r6_switch: assert property (@(posedge clk) disable iff (rst)
        (bank_switch && 32'(bank_target) < NUM_BANKS)
        |=> (cur_set == $past(bank_target) && prev_set == $past(cur_set)));

    a_r7_return: assert property (@(posedge clk) disable iff (rst)
        (bank_return && !bank_switch)
        |=> (cur_set == $past(prev_set) && $stable(prev_set)));

    a_r9_clamp: assert property (@(posedge clk) disable iff (rst)
        (bank_switch && 32'(bank_target) >= NUM_BANKS)
        |=> (cur_set == 3'd0 && prev_set == $past(cur_set)));

    a_r9_in_range: assert property (@(posedge clk) disable iff (rst)
        32'(cur_set) < NUM_BANKS && 32'(prev_set) < NUM_BANKS);

    a_r10_hilo_load: assert property (@(posedge clk) disable iff (rst)
        hilo_we |=> ({hi_data, lo_data} == $past(hilo_wdata)));

    a_r10_hilo_hold: assert property (@(posedge clk) disable iff (rst)
        !hilo_we |=> ($stable(hi_data) && $stable(lo_data)));

endmodule

bind shadow_regfile srf_checker #(.NUM_BANKS(NUM_BANKS)) u_srf_checker (.*);

// File: tb/shadow_regfile_bench.sv
module shadow_regfile_bench;

    localparam int unsigned NB = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bank_switch = 1'b0;
    logic [2:0]  bank_target = '0;
    logic        bank_return = 1'b0;
    logic [2:0]  cur_set, prev_set;
    logic [4:0]  src_a_idx = '0;
    logic [31:0] src_a_data;
    logic [4:0]  src_b_idx = '0;
    logic [31:0] src_b_data;
    logic        dst_we = 1'b0;
    logic [4:0]  dst_idx = '0;
    logic [31:0] dst_wdata = '0;
    logic        hilo_we = 1'b0;
    logic [63:0] hilo_wdata = '0;
    logic [31:0] hi_data, lo_data;

    always #2 clk = ~clk;

    shadow_regfile #(.NUM_BANKS(NB)) u_shadow_regfile (.*);

    logic [31:0] m_gpr [8][32];
    logic [2:0]  m_cur, m_prev;
    logic [31:0] m_hi, m_lo;
    int          n_vec = 0;
    int          n_bad = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] clampf(input logic [2:0] s);
        return (32'(s) < NB) ? s : 3'd0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] idx);
        if (idx == 5'd0) return 32'd0;
        if (dst_we && dst_idx == idx) return dst_wdata;
        return m_gpr[m_cur][idx];
    endfunction

    function automatic string rd_tag(input logic [4:0] idx);
        if (idx == 5'd0) return "R3";
        if (dst_we && dst_idx == idx) return "R4";
        return "R2";
    endfunction

    task automatic idle();
        bank_switch = 1'b0; bank_return = 1'b0; dst_we = 1'b0;
        hilo_we = 1'b0;
    endtask

    // Inputs are set just after a falling edge; checks the reads, clocks once,
    // updates the model, then checks the registered outputs.
    task automatic step();
        string stag;
        #1;
        chk(rd_tag(src_a_idx), 64'(src_a_data), 64'(exp_read(src_a_idx)));
        chk(rd_tag(src_b_idx), 64'(src_b_data), 64'(exp_read(src_b_idx)));
        if (bank_switch)
            stag = (32'(bank_target) >= NB) ? "R9" : (bank_return ? "R8" : "R6");
        else
            stag = bank_return ? "R7" : "R6";
        @(posedge clk);
        if (dst_we && dst_idx != 5'd0) m_gpr[m_cur][dst_idx] = dst_wdata;
        if (hilo_we) begin
            m_hi = hilo_wdata[63:32];
            m_lo = hilo_wdata[31:0];
        end
        if (bank_switch) begin
            m_prev = m_cur;
            m_cur  = clampf(bank_target);
        end else if (bank_return) begin
            m_cur = m_prev;
        end
        @(negedge clk);
        chk(stag, 64'(cur_set), 64'(m_cur));
        chk(stag, 64'(prev_set), 64'(m_prev));
        chk("R10", {hi_data, lo_data}, {m_hi, m_lo});
        idle();
    endtask

    initial begin
        #(4 * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] keep;
        void'($urandom(32'd2024));
        m_cur = '0; m_prev = '0; m_hi = '0; m_lo = '0;
        hilo_we = 1'b1; hilo_wdata = 64'hFFFF_0000_FFFF_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hilo_we = 1'b0;
        #1;
        // R1: state right after reset
        chk("R1", 64'(cur_set), 64'd0);
        chk("R1", 64'(prev_set), 64'd0);
        chk("R1", {hi_data, lo_data}, 64'd0);
        @(negedge clk);

        // Fill every live bank with distinct values.
        for (int b = 0; b < int'(NB); b++) begin
            bank_switch = 1'b1; bank_target = 3'(b);
            step();
            for (int r = 1; r < 32; r++) begin
                dst_we = 1'b1; dst_idx = 5'(r);
                dst_wdata = {8'(b), 8'(r), 16'($urandom)};
                src_a_idx = 5'(r); src_b_idx = 5'(r - 1);
                step();
            end
        end

        // R3: write to register 0 is discarded
        dst_we = 1'b1; dst_idx = 5'd0; dst_wdata = 32'hDEAD_BEEF;
        src_a_idx = 5'd0; step();
        src_a_idx = 5'd0; src_b_idx = 5'd0; #1;
        chk("R3", 64'(src_a_data), 64'd0);
        step();

        // R4: same-cycle forwarding to both ports
        dst_we = 1'b1; dst_idx = 5'd12; dst_wdata = 32'h1234_5678;
        src_a_idx = 5'd12; src_b_idx = 5'd12; #1;
        chk("R4", 64'(src_b_data), 64'h1234_5678);
        step();

        // R5: bank isolation
        bank_switch = 1'b1; bank_target = 3'd1; step();
        dst_we = 1'b1; dst_idx = 5'd5; dst_wdata = 32'h1111_1111; step();
        bank_switch = 1'b1; bank_target = 3'd2; step();
        src_a_idx = 5'd5; #1;
        chk("R5", 64'(src_a_data), 64'(m_gpr[2][5]));
        step();

        // R11: write during a switch cycle lands in the old bank (2)
        bank_switch = 1'b1; bank_target = 3'd3;
        dst_we = 1'b1; dst_idx = 5'd9; dst_wdata = 32'hABCD_0011; step();
        bank_return = 1'b1; step();
        src_a_idx = 5'd9; #1;
        chk("R11", 64'(src_a_data), 64'hABCD_0011);
        chk("R11", 64'(cur_set), 64'd2);
        step();

        // R8: switch and return together
        bank_switch = 1'b1; bank_target = 3'd4; bank_return = 1'b1; step();
        // R7: return afterwards
        bank_return = 1'b1; step();
        // R9: targets at and above the bank count
        bank_switch = 1'b1; bank_target = 3'd5; step();
        bank_switch = 1'b1; bank_target = 3'd7; step();

        // R10: result registers load then hold
        hilo_we = 1'b1; hilo_wdata = 64'h0123_4567_89AB_CDEF; step();
        step();
        chk("R10", 64'(hi_data), 64'h0123_4567);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            keep = $urandom;
            dst_we      = (keep[3:0] < 4'd11);
            dst_idx     = 5'($urandom);
            dst_wdata   = $urandom;
            src_a_idx   = keep[4] ? dst_idx : 5'($urandom);
            src_b_idx   = 5'($urandom);
            bank_switch = (keep[8:5] == 4'd0);
            bank_target = 3'($urandom);
            bank_return = (keep[12:9] == 4'd1);
            hilo_we     = (keep[15:13] == 3'd0);
            hilo_wdata  = {$urandom, $urandom};
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule